// File: doc/BRIEF.md
# Even-Agreement Run Detector

This block watches two single-bit data inputs, sampled on every rising clock edge, and raises its output while the inputs have been equal for an even, non-zero number of consecutive cycles. The run is counted up to and including the current cycle. The output is 1 on the second, fourth, sixth and later even-numbered cycles of an unbroken agreement run. It is 0 on odd-numbered cycles of a run and on any cycle where the inputs differ.

The block first reduces the input pair to a single mismatch signal. A one-flop tracker then records whether the agreement run completed so far has odd or even length. The output is formed from that flop and the live mismatch signal, so it follows the inputs within the same cycle, as a Mealy output does. Only the parity of the run is kept, never its length. Reset is synchronous and active low.

Top module: `even_agree_detector`

## Requirements
- R1: A clock edge with `rst_n` low puts the tracker into its even state whatever the inputs are. The first agreeing cycle after reset is released therefore gives `z` = 0.
- R2: In any cycle where `x_a` and `x_b` differ, `z` is 0.
- R3: The inputs agree when both are 0 or both are 1. A run may mix 00 and 11 cycles and still counts as one unbroken run.
- R4: In a cycle where the inputs agree and the run length, counting this cycle, is even (2, 4, 6, …), `z` is 1.
- R5: In a cycle where the inputs agree and the run length, counting this cycle, is odd, `z` is 0.
- R6: A single disagreeing cycle restarts the count. The next agreeing cycle counts as run length 1 and gives `z` = 0, and the one after it gives `z` = 1.
- R7: `z` depends on the present inputs within the cycle. A change of `x_a` or `x_b` between clock edges shows on `z` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x_a | input | 1 | First data input |
| x_b | input | 1 | Second data input |
| z | output | 1 | 1 while the inputs agree on an even-numbered cycle of their run |

## Verification
The bench aims at runs that switch between 00 and 11. A design that compared each input against its own previous value would break these runs and never reach `z` = 1 on them.

It places single disagreeing cycles in the middle of long runs. A tracker that skipped the restart would carry the old parity forward and raise `z` on the first cycle of the new run.

It changes the inputs between clock edges to catch an output that has been registered. Such an output would lag the inputs by one cycle.

It applies reset while the inputs agree and while they differ. A tracker that kept counting during reset would give `z` = 1 on the first cycle after release.

// File: rtl/agree_pkg.sv
// Package: agree_pkg
// Shared types for the even-agreement detector.
// Assumes: one flop is enough to hold the parity of the agreement run.
package agree_pkg;

    // Parity of the agreement run completed before the current cycle.
    typedef enum logic {
        RUN_EVEN = 1'b0,
        RUN_ODD  = 1'b1
    } run_par_e;

endpackage

// File: rtl/pair_compare.sv
// Module: pair_compare
// Reduces the two data inputs to one mismatch flag.
// Assumes: both inputs are synchronous to the block clock.
module pair_compare (
    input  logic a_in,
    input  logic b_in,
    output logic mismatch
);

    // Flag the cycle whenever the two inputs differ.
    always_comb begin
        mismatch = a_in ^ b_in;
    end

endmodule

// File: rtl/run_parity_tracker.sv
// Module: run_parity_tracker
// Keeps the parity of the present run of agreeing cycles.
// Assumes: synchronous active-low reset; a mismatch ends the run.
module run_parity_tracker
    import agree_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mismatch,
    output run_par_e par_q
);

    run_par_e par_d;

    // Next parity: a mismatch restarts the run, an agreement flips the parity.
    always_comb begin
        if (mismatch) begin
            par_d = RUN_EVEN;
        end else if (par_q == RUN_EVEN) begin
            par_d = RUN_ODD;
        end else begin
            par_d = RUN_EVEN;
        end
    end

    // Parity register with synchronous reset to the even state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= RUN_EVEN;
        end else begin
            par_q <= par_d;
        end
    end

endmodule

// File: rtl/even_run_output.sv
// Module: even_run_output
// Forms the Mealy output from the stored parity and the live mismatch flag.
// Assumes: an odd stored parity plus an agreeing cycle gives an even run.
module even_run_output
    import agree_pkg::*;
(
    input  run_par_e par_q,
    input  logic     mismatch,
    output logic     z_out
);

    // Raise the output only on an agreeing cycle that closes an even run.
    always_comb begin
        z_out = (par_q == RUN_ODD) && !mismatch;
    end

endmodule

// File: rtl/even_agree_detector.sv
// Module: even_agree_detector
// Top level: raises z while x_a and x_b have agreed for an even, non-zero
// number of clock cycles, counting the current cycle.
// Assumes: synchronous active-low reset; inputs change away from the edge.
module even_agree_detector
    import agree_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_a,
    input  logic x_b,
    output logic z
);

    logic     mismatch;
    run_par_e par_q;

    pair_compare u_cmp (
        .a_in     (x_a),
        .b_in     (x_b),
        .mismatch (mismatch)
    );

    run_parity_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch),
        .par_q    (par_q)
    );

    even_run_output u_out (
        .par_q    (par_q),
        .mismatch (mismatch),
        .z_out    (z)
    );

endmodule

// File: rtl/even_agree_detector_chk.sv
// Module: even_agree_detector_chk
// Port-level checker for even_agree_detector, attached with bind.
// Assumes: inputs are stable around the rising clock edge.
module even_agree_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic x_a,
    input logic x_b,
    input logic z
);

    logic prev_rst_n;

    // Remember whether the last edge applied reset.
    always_ff @(posedge clk) begin
        prev_rst_n <= rst_n;
    end

    // R1: the first cycle after a reset edge is in the even state.
    always_ff @(posedge clk) begin
        if (prev_rst_n === 1'b0 && x_a == x_b) begin
            a_r1_reset_even: assert (!z);
        end
    end

    // R2: differing inputs keep z low.
    a_r2_mismatch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (x_a != x_b) |-> !z);

    // R4: an agreeing cycle that gave z=0 is followed by z=1 if agreement holds.
    a_r4_second_agree_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_a == x_b) && $past(rst_n) && $past(x_a == x_b && !z)) |-> z);

    // R5: after z=1, a further agreeing cycle is odd and gives z=0.
    a_r5_after_high_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_a == x_b) && $past(x_a == x_b && z)) |-> !z);

    // R6: the first agreeing cycle after a mismatch gives z=0.
    a_r6_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_a == x_b) && $past(x_a != x_b)) |-> !z);

endmodule

bind even_agree_detector even_agree_detector_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x_a   (x_a),
    .x_b   (x_b),
    .z     (z)
);

// File: tb/even_agree_detector_tb.sv
// Bench for even_agree_detector: directed corner cases, then seeded random
// streams checked against a run-length reference model.
module even_agree_detector_tb;

    logic clk;
    logic rst_n;
    logic x_a;
    logic x_b;
    logic z;

    int n_vec;
    int n_bad;
    int run_prev;   // agreeing cycles completed before the present cycle

    even_agree_detector u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .x_a   (x_a),
        .x_b   (x_b),
        .z     (z)
    );

    // 100 MHz clock.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference: z is 1 when the inputs agree and the run, counting this cycle, is even.
    function automatic logic exp_z(logic a, logic b, int prev);
        return (a == b) && (prev % 2 == 1);
    endfunction

    task automatic check(logic actual, logic expected, string req);
        n_vec++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s: z actual=%b expected=%b (run_prev=%0d x_a=%b x_b=%b)",
                     req, actual, expected, run_prev, x_a, x_b);
        end
    endtask

    // One operating cycle: drive after the falling edge, check, then advance the model.
    task automatic apply(logic a, logic b, string req);
        string tag;
        @(negedge clk);
        x_a = a;
        x_b = b;
        #2;
        tag = req;
        if (tag == "") begin
            if (a != b)                tag = "R2";
            else if (run_prev % 2 == 1) tag = "R4";
            else                        tag = "R5";
        end
        check(z, exp_z(a, b, run_prev), tag);
        run_prev = (a == b) ? run_prev + 1 : 0;
    endtask

    // One reset cycle with the given inputs; the model restarts.
    task automatic reset_cycle(logic a, logic b);
        @(negedge clk);
        rst_n = 1'b0;
        x_a   = a;
        x_b   = b;
        run_prev = 0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        run_prev = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        n_vec = 0;
        n_bad = 0;
        run_prev = 0;
        rst_n = 1'b0;
        x_a = 1'b0;
        x_b = 1'b0;

        // R1: reset with varied inputs, then check in reset and after release.
        reset_cycle(1'b1, 1'b1);
        reset_cycle(1'b0, 1'b1);
        reset_cycle(1'b0, 1'b0);
        #2;
        check(z, 1'b0, "R1");
        reset_cycle(1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        x_a = 1'b1;
        x_b = 1'b1;
        #2;
        check(z, 1'b0, "R1");
        run_prev = 1;

        // R3: 00 after 11 continues the run (length 2).
        apply(1'b0, 1'b0, "R3");
        apply(1'b1, 1'b1, "R5");
        apply(0, 0, "R4");
        apply(1, 1, "R5");
        apply(1, 1, "R4");
        // R2: a mismatch in the middle of a long run.
        apply(1, 0, "R2");
        // R6: restart after the mismatch.
        apply(1, 1, "R6");
        apply(0, 0, "R6");
        apply(0, 1, "R2");
        apply(0, 0, "R6");
        apply(1, 0, "R2");
        apply(1, 1, "R6");
        apply(1, 1, "R6");
        apply(0, 0, "R5");

        // R7: inputs change between edges; z follows them before the edge.
        @(negedge clk);
        x_a = 1'b1;
        x_b = 1'b1;
        #1;
        check(z, 1'b1, "R7");
        x_b = 1'b0;
        #1;
        check(z, 1'b0, "R7");
        x_b = 1'b1;
        #1;
        check(z, 1'b1, "R7");
        x_a = 1'b0;
        #1;
        check(z, 1'b0, "R7");
        run_prev = 0;

        // Random streams, weighted toward agreement to build long runs.
        for (int i = 0; i < 3000; i++) begin
            int   r;
            logic v;
            r = $urandom % 100;
            v = 1'($urandom % 2);
            if (r < 80) apply(v, v, "");
            else        apply(v, ~v, "");
        end

        // R1: reset in the middle of an odd run clears the parity.
        apply(1, 1, "R6");
        reset_cycle(1'b1, 1'b1);
        release_reset();
        run_prev = 0;
        x_a = 1'b0;
        x_b = 1'b0;
        #2;
        check(z, 1'b0, "R1");
        run_prev = 1;
        apply(1, 1, "R4");

        finish_run();
    end

endmodule